// File: doc/BRIEF.md
# Paravirtual Block Device Register File (Legacy Memory-Mapped Layout)

This block is the register front end of a paravirtual block device that uses the legacy, version 1 memory-mapped layout. A host processor reaches it over a simple register bus. Each request carries an address, a size (byte, halfword or word), a direction and write data. The block answers every request one cycle later with read data and a fault flag. It holds the identity constants, a selectable 64-bit feature window for the device and for the driver, the set-up registers of a single queue, the notify, interrupt and device-status registers, and an 8-byte configuration space that carries the disk capacity.

A separate request engine walks the descriptors and moves the data. This block gives that engine what it needs:

- the raw queue parameters;
- the descriptor, available-ring and used-ring base addresses, captured when the driver signals that it is ready;
- a ready level;
- a one-cycle notify pulse with the queue index;
- a one-cycle device-reset pulse, which the engine uses to clear its used-ring counter.

The engine reports each returned buffer with a pulse on `used_evt`. That pulse raises the interrupt.

Top module: `vblk_regfile`

## Requirements
- R1: Word reads return fixed values: offset 0x000 gives 0x74726976, 0x004 gives 1, 0x008 gives 2, 0x00C gives 0x554D4551, and 0x034 gives the largest queue size, 8.
- R2: A read of 0x010 returns bits 32·s to 32·s+31 of the device feature vector, where s is the selector written at 0x014. Only bit 35 of that vector is set, so s=1 reads 0x8, s=0 reads 0, and any other s reads 0.
- R3: A write to 0x020 stores its value in the lower half of `drv_features` when the selector at 0x024 is 0, and in the upper half when it is 1.
- R4: The queue set-up registers come out of reset as follows: page size 0 (0x028), queue size 0 (0x038), alignment 0x1000 (0x03C), PFN 0 (0x040). Each register drives its output port, and the PFN can also be read back.
- R5: Byte offset k is the address minus the register base. A byte or halfword write at offset k replaces only byte lanes k (and k+1) of the 32-bit register. A byte or halfword read at offset k returns the register shifted right by 8·k and masked to the access size.
- R6: Offsets 0x100 to 0x107 hold a little-endian 64-bit capacity that resets to 0x32000. They accept byte reads and byte writes. A halfword or word access there faults.
- R7: These requests fault and change no state: a request to an unmapped offset, a read of a write-only register, a write to a read-only register, a size code of 3, and a queue-select write whose value is not 0.
- R8: A write to 0x050 gives one cycle of `notify_pulse` with the written value on `notify_index`. The cycle is the one that follows the request.
- R9: A `used_evt` pulse sets bit 0 of interrupt status (read at 0x060). `irq` is the OR of the status bits. A write to 0x064 clears the bits that are set in the written value. When a set and a clear arrive in the same cycle, the set wins.
- R10: Device status at 0x070 can be read and written. A write that leaves it at zero clears interrupt status and gives one cycle of `dev_reset`.
- R11: `queue_ready` follows status bit 2. A status write with bit 2 set captures these addresses:
  - descriptor base = PFN × page size;
  - available base = descriptor base + 16 × queue size;
  - used base = the next alignment boundary strictly above available base + 6 + 2 × queue size.
- R12: Each request taken with `req_valid` is answered with `rsp_valid` in exactly the next cycle. A cycle without a request is followed by `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the block |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data, least significant lanes used for sub-word |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and faults) |
| rsp_fault | output | 1 | Access fault |
| used_evt | input | 1 | Engine returned a buffer to the used ring |
| irq | output | 1 | Interrupt request |
| notify_pulse | output | 1 | Driver notified the queue |
| notify_index | output | 32 | Value written with the notify |
| dev_reset | output | 1 | Device reset pulse |
| queue_ready | output | 1 | Driver reports it is ready |
| drv_features | output | 64 | Features accepted by the driver |
| q_page_size | output | 32 | Guest page size in bytes |
| q_size | output | 32 | Queue size in entries |
| q_align | output | 32 | Used-ring alignment in bytes |
| q_pfn | output | 32 | Queue page number |
| desc_base | output | 64 | Captured descriptor table address |
| avail_base | output | 64 | Captured available ring address |
| used_base | output | 64 | Captured used ring address |

## Verification
A request sampled at clock edge N shows its result in the cycle after that edge, through exactly one register stage. In that same cycle the bench can see:

- the response data and fault flag;
- the new register value on its output port;
- `notify_pulse` or `dev_reset`;
- the captured ring addresses.

A `used_evt` held for one edge shows up on `irq` right after that edge. The bench drives every input on the falling edge and reads results on the following falling edge, which sits half a period after the updating edge. It then checks one more falling edge to confirm that each pulse has dropped.

// File: rtl/vblk_pkg.sv
package vblk_pkg;

    localparam int REG_AW = 12;
    localparam int DW     = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_t;

    localparam logic [REG_AW-1:0] OFF_MAGIC   = 12'h000;
    localparam logic [REG_AW-1:0] OFF_VERSION = 12'h004;
    localparam logic [REG_AW-1:0] OFF_DEVID   = 12'h008;
    localparam logic [REG_AW-1:0] OFF_VENDOR  = 12'h00C;
    localparam logic [REG_AW-1:0] OFF_DFEAT   = 12'h010;
    localparam logic [REG_AW-1:0] OFF_DFSEL   = 12'h014;
    localparam logic [REG_AW-1:0] OFF_GFEAT   = 12'h020;
    localparam logic [REG_AW-1:0] OFF_GFSEL   = 12'h024;
    localparam logic [REG_AW-1:0] OFF_PAGE    = 12'h028;
    localparam logic [REG_AW-1:0] OFF_QSEL    = 12'h030;
    localparam logic [REG_AW-1:0] OFF_QMAX    = 12'h034;
    localparam logic [REG_AW-1:0] OFF_QNUM    = 12'h038;
    localparam logic [REG_AW-1:0] OFF_QALIGN  = 12'h03C;
    localparam logic [REG_AW-1:0] OFF_QPFN    = 12'h040;
    localparam logic [REG_AW-1:0] OFF_NOTIFY  = 12'h050;
    localparam logic [REG_AW-1:0] OFF_ISR     = 12'h060;
    localparam logic [REG_AW-1:0] OFF_IACK    = 12'h064;
    localparam logic [REG_AW-1:0] OFF_STATUS  = 12'h070;
    localparam logic [REG_AW-1:0] OFF_CFG     = 12'h100;

    localparam logic [DW-1:0] ID_MAGIC  = 32'h7472_6976;
    localparam logic [DW-1:0] ID_VER    = 32'd1;
    localparam logic [DW-1:0] ID_DEV    = 32'd2;
    localparam logic [DW-1:0] ID_VENDOR = 32'h554D_4551;
    localparam int            ST_READY_BIT = 2;

    typedef struct packed {
        logic          rd_ok;
        logic          wr_ok;
        logic [DW-1:0] rd_reg;
        logic [DW-1:0] wr_cur;
    } dec_t;

    function automatic logic [DW-1:0] size_mask(acc_size_t sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_merge(logic [DW-1:0] old, logic [DW-1:0] wd,
                                                 acc_size_t sz, logic [1:0] off);
        logic [DW-1:0] m;
        m = size_mask(sz) << {off, 3'b000};
        if (sz == SZ_WORD) return wd;
        return (old & ~m) | ((wd << {off, 3'b000}) & m);
    endfunction

    function automatic logic [DW-1:0] lane_extract(logic [DW-1:0] r, acc_size_t sz,
                                                   logic [1:0] off);
        return (r >> {off, 3'b000}) & size_mask(sz);
    endfunction

endpackage

// File: rtl/vblk_cfg_space.sv
module vblk_cfg_space #(
    parameter int          NBYTES   = 8,
    parameter logic [63:0] INIT_VAL = 64'h32000,
    localparam int         IW       = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] bytes_q [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)                               bytes_q[i] <= INIT_VAL[8*i +: 8];
            else if (wr_en && idx == IW'(i))       bytes_q[i] <= wdata;
        end
    end

    assign rdata = bytes_q[idx];
endmodule

// File: rtl/vblk_irq_ctl.sv
module vblk_irq_ctl (
    input  logic        clk,
    input  logic        rst,
    input  logic        dev_rst,
    input  logic        set_used,
    input  logic        ack_en,
    input  logic [31:0] ack_mask,
    output logic [31:0] isr,
    output logic        irq
);
    logic used_q;

    always_ff @(posedge clk) begin
        if (rst || dev_rst)             used_q <= 1'b0;
        else if (set_used)              used_q <= 1'b1;
        else if (ack_en && ack_mask[0]) used_q <= 1'b0;
    end

    assign isr = {31'd0, used_q};
    assign irq = |isr;
endmodule

// File: rtl/vblk_ring_geom.sv
module vblk_ring_geom #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          latch,
    input  logic [31:0]   pfn,
    input  logic [31:0]   page,
    input  logic [31:0]   qnum,
    input  logic [31:0]   align,
    output logic [AW-1:0] desc_base,
    output logic [AW-1:0] avail_base,
    output logic [AW-1:0] used_base
);
    logic [AW-1:0] d_n, a_n, end_n, al_n, u_n;

    always_comb begin
        d_n   = AW'(pfn) * AW'(page);
        a_n   = d_n + (AW'(qnum) << 4);
        end_n = a_n + AW'(6) + (AW'(qnum) << 1);
        al_n  = AW'(align);
        u_n   = (end_n & ~(al_n - AW'(1))) + al_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_base  <= '0;
            avail_base <= '0;
            used_base  <= '0;
        end else if (latch) begin
            desc_base  <= d_n;
            avail_base <= a_n;
            used_base  <= u_n;
        end
    end
endmodule

// File: rtl/vblk_regfile.sv
module vblk_regfile
    import vblk_pkg::*;
#(
    parameter int          QUEUE_MAX    = 8,
    parameter logic [63:0] DEV_FEATURES = 64'h0000_0008_0000_0000,
    parameter logic [63:0] CAPACITY     = 64'h0000_0000_0003_2000,
    parameter logic [31:0] ALIGN_RESET  = 32'h0000_1000,
    parameter int          GEOM_AW      = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [11:0]        req_addr,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               rsp_fault,
    input  logic               used_evt,
    output logic               irq,
    output logic               notify_pulse,
    output logic [31:0]        notify_index,
    output logic               dev_reset,
    output logic               queue_ready,
    output logic [63:0]        drv_features,
    output logic [31:0]        q_page_size,
    output logic [31:0]        q_size,
    output logic [31:0]        q_align,
    output logic [31:0]        q_pfn,
    output logic [GEOM_AW-1:0] desc_base,
    output logic [GEOM_AW-1:0] avail_base,
    output logic [GEOM_AW-1:0] used_base
);
    localparam int CFG_BYTES = 8;
    localparam int CFG_IW    = $clog2(CFG_BYTES);
    localparam logic [31:0] NO_NOTIFY = '1;

    logic [31:0] dfsel_q, gfsel_q, status_q;
    logic [31:0] isr;
    logic [7:0]  cfg_byte;
    acc_size_t   sz;
    logic [1:0]  off;
    logic [REG_AW-1:0] base;
    logic        is_cfg, fault, wr_en, cfg_wr;
    logic [31:0] merged, rd_val;
    dec_t        dec;

    assign sz     = acc_size_t'(req_size);
    assign off    = req_addr[1:0];
    assign base   = {req_addr[REG_AW-1:2], 2'b00};
    assign is_cfg = req_addr[REG_AW-1:CFG_IW] == OFF_CFG[REG_AW-1:CFG_IW];

    always_comb begin
        dec = '0;
        case (base)
            OFF_MAGIC:   begin dec.rd_ok = 1'b1; dec.rd_reg = ID_MAGIC;  end
            OFF_VERSION: begin dec.rd_ok = 1'b1; dec.rd_reg = ID_VER;    end
            OFF_DEVID:   begin dec.rd_ok = 1'b1; dec.rd_reg = ID_DEV;    end
            OFF_VENDOR:  begin dec.rd_ok = 1'b1; dec.rd_reg = ID_VENDOR; end
            OFF_DFEAT: begin
                dec.rd_ok  = 1'b1;
                dec.rd_reg = (dfsel_q == 32'd0) ? DEV_FEATURES[31:0] :
                             (dfsel_q == 32'd1) ? DEV_FEATURES[63:32] : 32'd0;
            end
            OFF_DFSEL: begin dec.wr_ok = 1'b1; dec.wr_cur = dfsel_q; end
            OFF_GFEAT: begin
                dec.wr_ok  = 1'b1;
                dec.wr_cur = (gfsel_q == 32'd0) ? drv_features[31:0] :
                             (gfsel_q == 32'd1) ? drv_features[63:32] : 32'd0;
            end
            OFF_GFSEL:  begin dec.wr_ok = 1'b1; dec.wr_cur = gfsel_q;     end
            OFF_PAGE:   begin dec.wr_ok = 1'b1; dec.wr_cur = q_page_size; end
            OFF_QSEL:   begin dec.wr_ok = 1'b1; dec.wr_cur = 32'd0;       end
            OFF_QMAX:   begin dec.rd_ok = 1'b1; dec.rd_reg = 32'(QUEUE_MAX); end
            OFF_QNUM:   begin dec.wr_ok = 1'b1; dec.wr_cur = q_size;      end
            OFF_QALIGN: begin dec.wr_ok = 1'b1; dec.wr_cur = q_align;     end
            OFF_QPFN: begin
                dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
                dec.rd_reg = q_pfn; dec.wr_cur = q_pfn;
            end
            OFF_NOTIFY: begin dec.wr_ok = 1'b1; dec.wr_cur = NO_NOTIFY; end
            OFF_ISR:    begin dec.rd_ok = 1'b1; dec.rd_reg = isr;       end
            OFF_IACK:   begin dec.wr_ok = 1'b1; dec.wr_cur = 32'd0;     end
            OFF_STATUS: begin
                dec.rd_ok = 1'b1; dec.wr_ok = 1'b1;
                dec.rd_reg = status_q; dec.wr_cur = status_q;
            end
            default: dec = '0;
        endcase
    end

    always_comb begin
        merged = lane_merge(dec.wr_cur, req_wdata, sz, off);
        if (sz == SZ_BAD)
            fault = 1'b1;
        else if (is_cfg)
            fault = (sz != SZ_BYTE);
        else if (req_write)
            fault = !dec.wr_ok || (base == OFF_QSEL && merged != 32'd0);
        else
            fault = !dec.rd_ok;
        wr_en  = req_valid && req_write && !fault && !is_cfg;
        cfg_wr = req_valid && req_write && !fault && is_cfg;
        rd_val = is_cfg ? {24'd0, cfg_byte} : lane_extract(dec.rd_reg, sz, off);
    end

    logic wr_status, st_zero, st_ready;
    assign wr_status = wr_en && base == OFF_STATUS;
    assign st_zero   = wr_status && merged == 32'd0;
    assign st_ready  = wr_status && merged[ST_READY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            dfsel_q      <= '0;
            gfsel_q      <= '0;
            drv_features <= '0;
            q_page_size  <= '0;
            q_size       <= '0;
            q_align      <= ALIGN_RESET;
            q_pfn        <= '0;
            status_q     <= '0;
            notify_pulse <= 1'b0;
            notify_index <= NO_NOTIFY;
            dev_reset    <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_fault    <= 1'b0;
        end else begin
            notify_pulse <= 1'b0;
            notify_index <= NO_NOTIFY;
            dev_reset    <= st_zero;
            rsp_valid    <= req_valid;
            rsp_fault    <= req_valid && fault;
            rsp_rdata    <= (req_valid && !req_write && !fault) ? rd_val : 32'd0;
            if (wr_en) begin
                case (base)
                    OFF_DFSEL:  dfsel_q     <= merged;
                    OFF_GFSEL:  gfsel_q     <= merged;
                    OFF_GFEAT: begin
                        if (gfsel_q == 32'd0)      drv_features[31:0]  <= merged;
                        else if (gfsel_q == 32'd1) drv_features[63:32] <= merged;
                    end
                    OFF_PAGE:   q_page_size <= merged;
                    OFF_QNUM:   q_size      <= merged;
                    OFF_QALIGN: q_align     <= merged;
                    OFF_QPFN:   q_pfn       <= merged;
                    OFF_NOTIFY: begin
                        notify_pulse <= 1'b1;
                        notify_index <= merged;
                    end
                    OFF_STATUS: status_q    <= merged;
                    default: ;
                endcase
            end
        end
    end

    assign queue_ready = status_q[ST_READY_BIT];

    vblk_cfg_space #(.NBYTES(CFG_BYTES), .INIT_VAL(CAPACITY)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .idx(req_addr[CFG_IW-1:0]),
        .wdata(req_wdata[7:0]), .rdata(cfg_byte)
    );

    vblk_irq_ctl u_irq (
        .clk(clk), .rst(rst), .dev_rst(st_zero), .set_used(used_evt),
        .ack_en(wr_en && base == OFF_IACK), .ack_mask(merged),
        .isr(isr), .irq(irq)
    );

    vblk_ring_geom #(.AW(GEOM_AW)) u_geom (
        .clk(clk), .rst(rst), .latch(st_ready), .pfn(q_pfn), .page(q_page_size),
        .qnum(q_size), .align(q_align), .desc_base(desc_base),
        .avail_base(avail_base), .used_base(used_base)
    );
endmodule

// File: rtl/vblk_regfile_chk.sv
module vblk_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_fault,
    input logic        used_evt,
    input logic        irq,
    input logic        notify_pulse,
    input logic        dev_reset
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R12
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R12
    AST_MAGIC_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 12'h000 && req_size == 2'd2)
        |=> (rsp_rdata == 32'h7472_6976 && !rsp_fault));  // R1
    AST_CFG_BYTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[11:3] == 9'h020 && req_size != 2'd0) |=> rsp_fault);  // R6
    AST_NOTIFY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        notify_pulse |-> (rsp_valid && !rsp_fault &&
                          $past(req_write && req_addr[11:2] == 10'h014)));  // R8
    AST_USED_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (used_evt && !(req_valid && req_write && req_addr[11:2] == 10'h01C)) |=> irq);  // R9
    AST_RESET_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        dev_reset |-> !irq);  // R10
endmodule

bind vblk_regfile vblk_regfile_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault), .used_evt(used_evt),
    .irq(irq), .notify_pulse(notify_pulse), .dev_reset(dev_reset)
);

// File: tb/tb_vblk_regfile.sv
module tb_vblk_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        used_evt = 1'b0;
    logic        rsp_valid, rsp_fault, irq, notify_pulse, dev_reset, queue_ready;
    logic [31:0] rsp_rdata, notify_index, q_page_size, q_size, q_align, q_pfn;
    logic [63:0] drv_features, desc_base, avail_base, used_base;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    vblk_regfile dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .used_evt(used_evt), .irq(irq), .notify_pulse(notify_pulse),
        .notify_index(notify_index), .dev_reset(dev_reset), .queue_ready(queue_ready),
        .drv_features(drv_features), .q_page_size(q_page_size), .q_size(q_size),
        .q_align(q_align), .q_pfn(q_pfn), .desc_base(desc_base),
        .avail_base(avail_base), .used_base(used_base)
    );

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Drive at a falling edge; result is sampled on the next falling edge.
    task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] s,
                       input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [1:0] s, logic [31:0] exp);
        acc(1'b0, a, s, 32'd0);
        chk(req, $sformatf("read 0x%0h fault", a), {63'd0, rsp_fault}, 64'd0);
        chk(req, $sformatf("read 0x%0h data", a), {32'd0, rsp_rdata}, {32'd0, exp});
    endtask

    task automatic fault_chk(string req, logic wr, logic [11:0] a, logic [1:0] s,
                             logic [31:0] d);
        acc(wr, a, s, d);
        chk(req, $sformatf("fault at 0x%0h", a), {63'd0, rsp_fault}, 64'd1);
    endtask

    task automatic t_reset;
        chk("R12", "rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
        chk("R4", "align reset", {32'd0, q_align}, 64'h1000);
        chk("R4", "size reset", {32'd0, q_size}, 64'd0);
        chk("R4", "page reset", {32'd0, q_page_size}, 64'd0);
        chk("R4", "pfn reset", {32'd0, q_pfn}, 64'd0);
        chk("R9", "irq reset", {63'd0, irq}, 64'd0);
        chk("R11", "ready reset", {63'd0, queue_ready}, 64'd0);
        chk("R3", "drv feat reset", drv_features, 64'd0);
    endtask

    task automatic t_ident;
        rd_chk("R1", 12'h000, 2'd2, 32'h7472_6976);
        rd_chk("R1", 12'h004, 2'd2, 32'd1);
        rd_chk("R1", 12'h008, 2'd2, 32'd2);
        rd_chk("R1", 12'h00C, 2'd2, 32'h554D_4551);
        rd_chk("R1", 12'h034, 2'd2, 32'd8);
    endtask

    task automatic t_features;
        acc(1'b1, 12'h014, 2'd2, 32'd1);
        rd_chk("R2", 12'h010, 2'd2, 32'h8);
        acc(1'b1, 12'h014, 2'd2, 32'd0);
        rd_chk("R2", 12'h010, 2'd2, 32'h0);
        acc(1'b1, 12'h014, 2'd2, 32'd2);
        rd_chk("R2", 12'h010, 2'd2, 32'h0);
    endtask

    task automatic t_drv_features;
        acc(1'b1, 12'h024, 2'd2, 32'd1);
        acc(1'b1, 12'h020, 2'd2, 32'hAABB_CCDD);
        chk("R3", "upper half", drv_features, 64'hAABB_CCDD_0000_0000);
        acc(1'b1, 12'h024, 2'd2, 32'd0);
        acc(1'b1, 12'h020, 2'd2, 32'h0000_0011);
        chk("R3", "lower half", drv_features, 64'hAABB_CCDD_0000_0011);
    endtask

    task automatic t_queue;
        acc(1'b1, 12'h028, 2'd2, 32'h1000);
        chk("R4", "page out", {32'd0, q_page_size}, 64'h1000);
        acc(1'b1, 12'h038, 2'd2, 32'd8);
        chk("R4", "size out", {32'd0, q_size}, 64'd8);
        acc(1'b1, 12'h040, 2'd2, 32'h80);
        chk("R4", "pfn out", {32'd0, q_pfn}, 64'h80);
        rd_chk("R4", 12'h040, 2'd2, 32'h80);
    endtask

    task automatic t_subword;
        acc(1'b1, 12'h040, 2'd2, 32'h1122_3344);
        acc(1'b1, 12'h041, 2'd0, 32'h0000_00AA);
        chk("R5", "byte merge", {32'd0, q_pfn}, 64'h1122_AA44);
        acc(1'b1, 12'h042, 2'd1, 32'h0000_5566);
        chk("R5", "half merge", {32'd0, q_pfn}, 64'h5566_AA44);
        rd_chk("R5", 12'h043, 2'd0, 32'h55);
        rd_chk("R5", 12'h041, 2'd1, 32'h66AA);
        acc(1'b1, 12'h040, 2'd2, 32'h80);
    endtask

    task automatic t_cfg;
        rd_chk("R6", 12'h100, 2'd0, 32'h00);
        rd_chk("R6", 12'h101, 2'd0, 32'h20);
        rd_chk("R6", 12'h102, 2'd0, 32'h03);
        rd_chk("R6", 12'h107, 2'd0, 32'h00);
        fault_chk("R6", 1'b0, 12'h100, 2'd2, 32'd0);
        fault_chk("R6", 1'b1, 12'h104, 2'd1, 32'h1234);
        rd_chk("R6", 12'h104, 2'd0, 32'h00);
        acc(1'b1, 12'h104, 2'd0, 32'h5A);
        rd_chk("R6", 12'h104, 2'd0, 32'h5A);
    endtask

    task automatic t_faults;
        fault_chk("R7", 1'b0, 12'h014, 2'd2, 32'd0);
        fault_chk("R7", 1'b1, 12'h000, 2'd2, 32'd5);
        fault_chk("R7", 1'b0, 12'h080, 2'd2, 32'd0);
        fault_chk("R7", 1'b1, 12'h030, 2'd2, 32'd1);
        fault_chk("R7", 1'b1, 12'h040, 2'd3, 32'hDEAD);
        chk("R7", "pfn untouched by faulting write", {32'd0, q_pfn}, 64'h80);
        acc(1'b1, 12'h030, 2'd2, 32'd0);
        chk("R7", "queue select 0 accepted", {63'd0, rsp_fault}, 64'd0);
    endtask

    task automatic t_notify;
        acc(1'b1, 12'h050, 2'd2, 32'd0);
        chk("R8", "notify pulse", {63'd0, notify_pulse}, 64'd1);
        chk("R8", "notify index", {32'd0, notify_index}, 64'd0);
        @(negedge clk);
        chk("R8", "notify drops", {63'd0, notify_pulse}, 64'd0);
        chk("R12", "no rsp when idle", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_irq;
        @(negedge clk); used_evt = 1'b1;
        @(negedge clk); used_evt = 1'b0;
        chk("R9", "irq after used", {63'd0, irq}, 64'd1);
        rd_chk("R9", 12'h060, 2'd2, 32'd1);
        acc(1'b1, 12'h064, 2'd2, 32'd0);
        chk("R9", "ack of zero keeps irq", {63'd0, irq}, 64'd1);
        acc(1'b1, 12'h064, 2'd2, 32'd1);
        chk("R9", "ack clears irq", {63'd0, irq}, 64'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h064; req_size = 2'd2;
        req_wdata = 32'd1; used_evt = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; used_evt = 1'b0;
        chk("R9", "set wins over ack", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_status;
        acc(1'b1, 12'h070, 2'd2, 32'h7);
        chk("R11", "ready", {63'd0, queue_ready}, 64'd1);
        chk("R11", "desc base", desc_base, 64'h8_0000);
        chk("R11", "avail base", avail_base, 64'h8_0080);
        chk("R11", "used base", used_base, 64'h8_1000);
        rd_chk("R10", 12'h070, 2'd2, 32'h7);
        acc(1'b1, 12'h03C, 2'd2, 32'd4);
        acc(1'b1, 12'h070, 2'd2, 32'hF);
        chk("R11", "used base align 4", used_base, 64'h8_0098);
        chk("R10", "no reset on nonzero", {63'd0, dev_reset}, 64'd0);
        acc(1'b1, 12'h070, 2'd2, 32'd0);
        chk("R10", "dev_reset pulse", {63'd0, dev_reset}, 64'd1);
        chk("R10", "irq cleared", {63'd0, irq}, 64'd0);
        chk("R11", "ready drops", {63'd0, queue_ready}, 64'd0);
        rd_chk("R10", 12'h060, 2'd2, 32'd0);
        chk("R10", "dev_reset drops", {63'd0, dev_reset}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ident();
        t_features();
        t_drv_features();
        t_queue();
        t_subword();
        t_cfg();
        t_faults();
        t_notify();
        t_irq();
        t_status();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule